// File: doc/BRIEF.md
# Receive Packet Poll-and-Fetch Engine

This engine runs on the host side of a byte-indexed Ethernet controller and empties the controller's receive buffer one packet per poll. A pulse on `poll_start` begins a fixed access sequence on the controller's index/data bus. The engine first quiets the controller's interrupt mask, then reads and clears the interrupt status. It then peeks the receive-ready marker. When a packet is waiting, it reads the packet's 4-byte header and chooses one of three outcomes.

A good packet is streamed out one byte per transfer on a valid/ready port, with its length and a last flag. A runt packet, or one whose status reports an error, is drained: its words are read and thrown away. An impossible length or marker makes the engine request a controller reset. That request is raised only once no transmission is in flight. Every poll ends by restoring the active interrupt mask and pulsing `poll_done` with a result code.

The output stream follows the valid/ready rules. A byte is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte, `out_last` and `out_len` hold their values. The engine buffers at most one bus word. It issues no further bus read until every byte of that word has been accepted, so a slow consumer stalls the controller bus rather than losing data.

Top module: `rx_poll_fetch`

## Requirements
- R1: After `poll_start`, the first bus operations are an index write of 0xFF followed by a data write of 0x80, then an index write of 0xFE and a data read. The byte read is written back unchanged, to index 0xFE, as the next index write and data write. That byte appears on `irq_status` from then on.
- R2: The marker peek is an index write of 0xF0 followed by two data reads. The marker is the low byte lane of the second read. A marker of 0 ends the poll with result 0 (none) and no header read.
- R3: A marker above 1 ends the poll with result 3 (fault) and sets the reset-pending state. No header read is made.
- R4: A marker of 1 leads to an index write of 0xF2 and ceil(4/BUS_BYTES) data reads. The bytes are taken lowest lane first. Header bytes 0 and 1 form the little-endian status, and bytes 2 and 3 form the little-endian length.
- R5: A length below MIN_LEN (default 64), including 0, is drained. The engine makes exactly ceil(length/BUS_BYTES) further data reads, with no stream output, and the result is 2 (drain).
- R6: A length above MAX_LEN (default 1536) gives result 3 (fault) and sets reset pending, with no further data reads.
- R7: A length in range with any status bit under ERR_MASK (default 0xBF00) set is drained as in R5. Status bits outside the mask do not prevent delivery.
- R8: Any other packet is delivered. The engine makes ceil(length/BUS_BYTES) data reads and outputs exactly `length` bytes in buffer order, lowest lane of each word first. The surplus lanes of the last word are dropped. `out_last` is high only on the final byte, `out_len` carries the length, and the result is 1 (deliver).
- R9: The output stream holds byte, last flag and length while it is stalled. No bus request is raised while a byte is being offered.
- R10: `reset_req` pulses for one cycle near the end of a poll when reset is pending and `tx_busy` is low, and that clears the pending state. While `tx_busy` is high, the pending state carries over to later polls.
- R11: Every poll ends with an index write of 0xFF and a data write of 0x83. The write's acknowledge is followed on the next cycle by a one-cycle `poll_done`, with `poll_result` holding the code.
- R12: A bus request holds `nic_req`, `nic_kind` and `nic_wdata` until `nic_ack` is sampled high. `nic_kind` is 0 for an index write, 1 for a data write and 2 for a data read. Read data is taken from `nic_rdata` on the acknowledging edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_start | input | 1 | Pulse to begin one poll while idle |
| tx_busy | input | 1 | High while a transmission is in flight |
| nic_req | output | 1 | Controller bus request |
| nic_kind | output | 2 | 0 index write, 1 data write, 2 data read |
| nic_wdata | output | 8*BUS_BYTES | Index or data value, zero-extended |
| nic_ack | input | 1 | Controller accepts the request on this edge |
| nic_rdata | input | 8*BUS_BYTES | Read data, valid with `nic_ack` |
| out_valid | output | 1 | Payload byte offered |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final byte of the packet |
| out_len | output | 16 | Length of the current packet |
| irq_status | output | 8 | Interrupt status read in the latest poll |
| poll_done | output | 1 | One-cycle pulse at the end of a poll |
| poll_result | output | 2 | 0 none, 1 deliver, 2 drain, 3 fault |
| reset_req | output | 1 | One-cycle controller reset request |

## Verification
Each engine result is due at a known offset from the bus acknowledge that causes it. A payload byte is offered one cycle after the acknowledging edge of its read. `reset_req` rises one cycle after the marker or header decision has moved the engine to its reset check. `poll_done` and the final `poll_result` appear one cycle after the acknowledge of the closing mask write. The bench's controller model and stream consumer drive `nic_ack`, `nic_rdata` and `out_ready` at the falling edge and record transfers there, so every value is sampled half a cycle after the edge that set it. Each scenario waits for `poll_done` with slack, and only then compares the recorded read counts, written values, bytes and pulse counts against figures worked out from the header it planted.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic [1:0] {
    BK_INDEX = 2'd0,
    BK_WRITE = 2'd1,
    BK_READ  = 2'd2
  } bus_kind_e;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_DELIVER = 2'd1,
    RES_DRAIN   = 2'd2,
    RES_FAULT   = 2'd3
  } poll_res_e;

  typedef enum logic [1:0] {
    CL_DELIVER = 2'd0,
    CL_DRAIN   = 2'd1,
    CL_FAULT   = 2'd2
  } pkt_class_e;

  localparam logic [7:0] IX_MASK   = 8'hFF;
  localparam logic [7:0] IX_STATUS = 8'hFE;
  localparam logic [7:0] IX_PEEK   = 8'hF0;
  localparam logic [7:0] IX_FETCH  = 8'hF2;

  localparam logic [7:0] MASK_QUIET  = 8'h80;
  localparam logic [7:0] MASK_ACTIVE = 8'h83;

  localparam int HDR_BYTES = 4;
endpackage

// File: rtl/rxp_hdr_collect.sv
module rxp_hdr_collect #(
  parameter int BUS_BYTES = 2,
  localparam int BUS_W     = 8 * BUS_BYTES,
  localparam int HDR_WORDS = (rxp_pkg::HDR_BYTES + BUS_BYTES - 1) / BUS_BYTES,
  localparam int IDX_W     = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [BUS_W-1:0] word,
  output logic [31:0]      hdr
);
  // One byte register per header byte; each picks its lane from the word
  // whose index covers it.
  for (genvar b = 0; b < rxp_pkg::HDR_BYTES; b++) begin : g_byte
    localparam int WSEL = b / BUS_BYTES;
    localparam int LANE = b % BUS_BYTES;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hdr[8*b +: 8] <= '0;
      end else if (cap_en && (cap_idx == IDX_W'(WSEL))) begin
        hdr[8*b +: 8] <= word[8*LANE +: 8];
      end
    end
  end
endmodule

// File: rtl/rxp_classify.sv
module rxp_classify #(
  parameter int          MIN_LEN  = 64,
  parameter int          MAX_LEN  = 1536,
  parameter logic [15:0] ERR_MASK = 16'hBF00
) (
  input  logic [31:0]         hdr,
  output logic [15:0]         pkt_len,
  output rxp_pkg::pkt_class_e pkt_cls
);
  import rxp_pkg::*;

  logic [15:0] stat;

  assign stat    = hdr[15:0];
  assign pkt_len = hdr[31:16];

  // Priority: runt first, then impossible length, then error status.
  always_comb begin
    if (pkt_len < 16'(MIN_LEN)) begin
      pkt_cls = CL_DRAIN;
    end else if (pkt_len > 16'(MAX_LEN)) begin
      pkt_cls = CL_FAULT;
    end else if ((stat & ERR_MASK) != 16'h0000) begin
      pkt_cls = CL_DRAIN;
    end else begin
      pkt_cls = CL_DELIVER;
    end
  end
endmodule

// File: rtl/rxp_unpack.sv
module rxp_unpack #(
  parameter int BUS_BYTES = 2,
  localparam int BUS_W  = 8 * BUS_BYTES,
  localparam int LANE_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1,
  localparam int CNT_W  = $clog2(BUS_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      start_len,
  input  logic             load,
  input  logic [BUS_W-1:0] word,
  output logic             busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);
  logic [BUS_W-1:0]  word_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0]  lanes_left;
  logic [15:0]       bytes_left;
  logic              fire;

  assign out_valid = (lanes_left != '0);
  assign busy      = out_valid;
  assign out_data  = 8'(word_q >> {lane_q, 3'b000});
  assign out_last  = (bytes_left == 16'd1);
  assign fire      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q     <= '0;
      lane_q     <= '0;
      lanes_left <= '0;
      bytes_left <= '0;
    end else if (start) begin
      bytes_left <= start_len;
    end else if (load) begin
      word_q     <= word;
      lane_q     <= '0;
      lanes_left <= (bytes_left >= 16'(BUS_BYTES)) ? CNT_W'(BUS_BYTES)
                                                   : CNT_W'(bytes_left);
    end else if (fire) begin
      lane_q     <= lane_q + 1'b1;
      lanes_left <= lanes_left - 1'b1;
      bytes_left <= bytes_left - 16'd1;
    end
  end

  // R9: an offered byte stays put until taken
  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9: a new word only arrives once the previous one is fully consumed
  a_r9_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/rxp_poll_fsm.sv
module rxp_poll_fsm #(
  parameter int BUS_BYTES = 2,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1536,
  localparam int BUS_W     = 8 * BUS_BYTES,
  localparam int HDR_WORDS = (rxp_pkg::HDR_BYTES + BUS_BYTES - 1) / BUS_BYTES,
  localparam int IDX_W     = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1,
  localparam int LANE_SH   = $clog2(BUS_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                poll_start,
  input  logic                tx_busy,
  output logic                nic_req,
  output logic [1:0]          nic_kind,
  output logic [BUS_W-1:0]    nic_wdata,
  input  logic                nic_ack,
  input  logic [7:0]          rdata_lo,
  output logic                hdr_cap,
  output logic [IDX_W-1:0]    hdr_idx,
  input  rxp_pkg::pkt_class_e pkt_cls,
  input  logic [15:0]         pkt_len,
  output logic                unp_start,
  output logic                unp_load,
  input  logic                unp_busy,
  output logic [7:0]          irq_status,
  output logic                poll_done,
  output logic [1:0]          poll_result,
  output logic                reset_req
);
  import rxp_pkg::*;

  typedef enum logic [4:0] {
    S_IDLE, S_MASK_IDX, S_MASK_WR, S_ISR_IDX, S_ISR_RD, S_CLR_IDX, S_CLR_WR,
    S_PEEK_IDX, S_PEEK_DUMMY, S_PEEK_MARK, S_HDR_IDX, S_HDR_RD, S_CLASSIFY,
    S_DRAIN_RD, S_DLV_RD, S_DLV_WAIT, S_RST_CHK, S_UNMASK_IDX, S_UNMASK_WR
  } st_e;

  st_e         state;
  logic [7:0]  irq_q;
  logic        pending;
  poll_res_e   result;
  logic        done_q;
  logic        rreq_q;
  logic [15:0] words_left;
  logic [15:0] word_need;

  assign word_need = 16'((17'(pkt_len) + 17'(BUS_BYTES - 1)) >> LANE_SH);

  // Bus operation presented in each state
  always_comb begin
    nic_req   = 1'b0;
    nic_kind  = BK_INDEX;
    nic_wdata = '0;
    unique case (state)
      S_MASK_IDX:   begin nic_req = 1'b1; nic_kind = BK_INDEX; nic_wdata = BUS_W'(IX_MASK);     end
      S_MASK_WR:    begin nic_req = 1'b1; nic_kind = BK_WRITE; nic_wdata = BUS_W'(MASK_QUIET);  end
      S_ISR_IDX:    begin nic_req = 1'b1; nic_kind = BK_INDEX; nic_wdata = BUS_W'(IX_STATUS);   end
      S_ISR_RD:     begin nic_req = 1'b1; nic_kind = BK_READ;                                   end
      S_CLR_IDX:    begin nic_req = 1'b1; nic_kind = BK_INDEX; nic_wdata = BUS_W'(IX_STATUS);   end
      S_CLR_WR:     begin nic_req = 1'b1; nic_kind = BK_WRITE; nic_wdata = BUS_W'(irq_q);       end
      S_PEEK_IDX:   begin nic_req = 1'b1; nic_kind = BK_INDEX; nic_wdata = BUS_W'(IX_PEEK);     end
      S_PEEK_DUMMY: begin nic_req = 1'b1; nic_kind = BK_READ;                                   end
      S_PEEK_MARK:  begin nic_req = 1'b1; nic_kind = BK_READ;                                   end
      S_HDR_IDX:    begin nic_req = 1'b1; nic_kind = BK_INDEX; nic_wdata = BUS_W'(IX_FETCH);    end
      S_HDR_RD:     begin nic_req = 1'b1; nic_kind = BK_READ;                                   end
      S_DRAIN_RD:   begin nic_req = 1'b1; nic_kind = BK_READ;                                   end
      S_DLV_RD:     begin nic_req = 1'b1; nic_kind = BK_READ;                                   end
      S_UNMASK_IDX: begin nic_req = 1'b1; nic_kind = BK_INDEX; nic_wdata = BUS_W'(IX_MASK);     end
      S_UNMASK_WR:  begin nic_req = 1'b1; nic_kind = BK_WRITE; nic_wdata = BUS_W'(MASK_ACTIVE); end
      default:      begin end
    endcase
  end

  assign hdr_cap   = (state == S_HDR_RD) && nic_ack;
  assign unp_start = (state == S_CLASSIFY) && (pkt_cls == CL_DELIVER);
  assign unp_load  = (state == S_DLV_RD) && nic_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      irq_q      <= '0;
      pending    <= 1'b0;
      result     <= RES_NONE;
      done_q     <= 1'b0;
      rreq_q     <= 1'b0;
      words_left <= '0;
      hdr_idx    <= '0;
    end else begin
      done_q <= 1'b0;
      rreq_q <= 1'b0;
      unique case (state)
        S_IDLE:       if (poll_start) state <= S_MASK_IDX;
        S_MASK_IDX:   if (nic_ack) state <= S_MASK_WR;
        S_MASK_WR:    if (nic_ack) state <= S_ISR_IDX;
        S_ISR_IDX:    if (nic_ack) state <= S_ISR_RD;
        S_ISR_RD: if (nic_ack) begin
          irq_q <= rdata_lo;
          state <= S_CLR_IDX;
        end
        S_CLR_IDX:    if (nic_ack) state <= S_CLR_WR;
        S_CLR_WR:     if (nic_ack) state <= S_PEEK_IDX;
        S_PEEK_IDX:   if (nic_ack) state <= S_PEEK_DUMMY;
        S_PEEK_DUMMY: if (nic_ack) state <= S_PEEK_MARK;
        S_PEEK_MARK: if (nic_ack) begin
          if (rdata_lo == 8'd1) begin
            hdr_idx <= '0;
            state   <= S_HDR_IDX;
          end else if (rdata_lo > 8'd1) begin
            pending <= 1'b1;
            result  <= RES_FAULT;
            state   <= S_RST_CHK;
          end else begin
            result  <= RES_NONE;
            state   <= S_RST_CHK;
          end
        end
        S_HDR_IDX:    if (nic_ack) state <= S_HDR_RD;
        S_HDR_RD: if (nic_ack) begin
          if (hdr_idx == IDX_W'(HDR_WORDS - 1)) state <= S_CLASSIFY;
          else hdr_idx <= hdr_idx + 1'b1;
        end
        S_CLASSIFY: begin
          unique case (pkt_cls)
            CL_DELIVER: begin
              result     <= RES_DELIVER;
              words_left <= word_need;
              state      <= S_DLV_RD;
            end
            CL_DRAIN: begin
              result     <= RES_DRAIN;
              words_left <= word_need;
              state      <= (word_need == 16'd0) ? S_RST_CHK : S_DRAIN_RD;
            end
            default: begin
              result  <= RES_FAULT;
              pending <= 1'b1;
              state   <= S_RST_CHK;
            end
          endcase
        end
        S_DRAIN_RD: if (nic_ack) begin
          words_left <= words_left - 16'd1;
          if (words_left == 16'd1) state <= S_RST_CHK;
        end
        S_DLV_RD: if (nic_ack) begin
          words_left <= words_left - 16'd1;
          state      <= S_DLV_WAIT;
        end
        S_DLV_WAIT: if (!unp_busy) begin
          state <= (words_left == 16'd0) ? S_RST_CHK : S_DLV_RD;
        end
        S_RST_CHK: begin
          if (pending && !tx_busy) begin
            rreq_q  <= 1'b1;
            pending <= 1'b0;
          end
          state <= S_UNMASK_IDX;
        end
        S_UNMASK_IDX: if (nic_ack) state <= S_UNMASK_WR;
        S_UNMASK_WR: if (nic_ack) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign irq_status  = irq_q;
  assign poll_done   = done_q;
  assign poll_result = result;
  assign reset_req   = rreq_q;

  // R12: a pending bus request is held unchanged until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    nic_req && !nic_ack |=> nic_req && $stable(nic_kind) && $stable(nic_wdata));

  // R10: a reset request is only raised when no transmission was in flight
  a_r10_reset_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !$past(tx_busy));

  // R11: completion follows the active mask write
  a_r11_done_after_mask: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done |-> $past(nic_kind) == 2'd1 && $past(nic_wdata) == BUS_W'(MASK_ACTIVE)
                  && $past(nic_ack));

  // R8: a delivered packet always has a legal length
  a_r8_deliver_len: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done && poll_result == 2'd1 |-> pkt_len >= 16'(MIN_LEN) && pkt_len <= 16'(MAX_LEN));
endmodule

// File: rtl/rx_poll_fetch.sv
module rx_poll_fetch #(
  parameter int          BUS_BYTES = 2,
  parameter int          MIN_LEN   = 64,
  parameter int          MAX_LEN   = 1536,
  parameter logic [15:0] ERR_MASK  = 16'hBF00,
  localparam int BUS_W     = 8 * BUS_BYTES,
  localparam int HDR_WORDS = (rxp_pkg::HDR_BYTES + BUS_BYTES - 1) / BUS_BYTES,
  localparam int IDX_W     = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_start,
  input  logic             tx_busy,
  output logic             nic_req,
  output logic [1:0]       nic_kind,
  output logic [BUS_W-1:0] nic_wdata,
  input  logic             nic_ack,
  input  logic [BUS_W-1:0] nic_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [15:0]      out_len,
  output logic [7:0]       irq_status,
  output logic             poll_done,
  output logic [1:0]       poll_result,
  output logic             reset_req
);
  logic                hdr_cap;
  logic [IDX_W-1:0]    hdr_idx;
  logic [31:0]         hdr;
  logic [15:0]         pkt_len;
  rxp_pkg::pkt_class_e pkt_cls;
  logic                unp_start;
  logic                unp_load;
  logic                unp_busy;

  rxp_poll_fsm #(
    .BUS_BYTES (BUS_BYTES),
    .MIN_LEN   (MIN_LEN),
    .MAX_LEN   (MAX_LEN)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_start  (poll_start),
    .tx_busy     (tx_busy),
    .nic_req     (nic_req),
    .nic_kind    (nic_kind),
    .nic_wdata   (nic_wdata),
    .nic_ack     (nic_ack),
    .rdata_lo    (nic_rdata[7:0]),
    .hdr_cap     (hdr_cap),
    .hdr_idx     (hdr_idx),
    .pkt_cls     (pkt_cls),
    .pkt_len     (pkt_len),
    .unp_start   (unp_start),
    .unp_load    (unp_load),
    .unp_busy    (unp_busy),
    .irq_status  (irq_status),
    .poll_done   (poll_done),
    .poll_result (poll_result),
    .reset_req   (reset_req)
  );

  rxp_hdr_collect #(.BUS_BYTES(BUS_BYTES)) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (hdr_cap),
    .cap_idx (hdr_idx),
    .word    (nic_rdata),
    .hdr     (hdr)
  );

  rxp_classify #(
    .MIN_LEN  (MIN_LEN),
    .MAX_LEN  (MAX_LEN),
    .ERR_MASK (ERR_MASK)
  ) u_cls (
    .hdr     (hdr),
    .pkt_len (pkt_len),
    .pkt_cls (pkt_cls)
  );

  rxp_unpack #(.BUS_BYTES(BUS_BYTES)) u_unp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (unp_start),
    .start_len (pkt_len),
    .load      (unp_load),
    .word      (nic_rdata),
    .busy      (unp_busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  assign out_len = pkt_len;

  // R9: the controller bus is idle whenever a byte is being offered
  a_r9_no_read_while_offering: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !nic_req);

  // R9: the length travels unchanged with a stalled byte
  a_r9_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_len));
endmodule

// File: tb/rx_poll_fetch_tb.sv
`timescale 1ns/1ps
module rx_poll_fetch_tb;
  localparam int B  = 2;
  localparam int BW = 8 * B;
  localparam int HW = (4 + B - 1) / B;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          poll_start = 1'b0;
  logic          tx_busy = 1'b0;
  logic          nic_req;
  logic [1:0]    nic_kind;
  logic [BW-1:0] nic_wdata;
  logic          nic_ack = 1'b0;
  logic [BW-1:0] nic_rdata = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;
  logic          out_last;
  logic [15:0]   out_len;
  logic [7:0]    irq_status;
  logic          poll_done;
  logic [1:0]    poll_result;
  logic          reset_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_poll_fetch #(.BUS_BYTES(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .poll_start(poll_start), .tx_busy(tx_busy),
    .nic_req(nic_req), .nic_kind(nic_kind), .nic_wdata(nic_wdata),
    .nic_ack(nic_ack), .nic_rdata(nic_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_len(out_len), .irq_status(irq_status),
    .poll_done(poll_done), .poll_result(poll_result), .reset_req(reset_req)
  );

  // ---------------- controller model ----------------
  logic [7:0]    mem [0:2047];
  logic [7:0]    marker = 8'd0;
  logic [7:0]    isr_v = 8'd0;
  logic [7:0]    cur_idx = 8'd0;
  int            ptr = 0;
  int            wait_n = 0;
  int            wcnt = 0;
  int            f2_reads, peek_reads, isr_wb, isr_wb_cnt;
  int            imr_first, imr_last, imr_cnt;
  int            bus_hold_err = 0;
  logic          prev_wait = 1'b0;
  logic [1:0]    prev_kind = '0;
  logic [BW-1:0] prev_wdata = '0;

  always @(negedge clk) begin
    if (prev_wait && !(nic_req && nic_kind == prev_kind && nic_wdata == prev_wdata))
      bus_hold_err++;
    nic_ack = 1'b0;
    if (nic_req) begin
      if (wcnt >= wait_n) begin
        nic_ack = 1'b1;
        wcnt = 0;
        case (nic_kind)
          2'd0: cur_idx = nic_wdata[7:0];
          2'd1: begin
            if (cur_idx == 8'hFF) begin
              if (imr_cnt == 0) imr_first = int'(nic_wdata);
              imr_last = int'(nic_wdata);
              imr_cnt++;
            end else if (cur_idx == 8'hFE) begin
              isr_wb = int'(nic_wdata);
              isr_wb_cnt++;
            end
          end
          default: begin
            nic_rdata = '0;
            if (cur_idx == 8'hFE) nic_rdata = BW'(isr_v);
            else if (cur_idx == 8'hF0) begin
              nic_rdata = {8'hA5, marker};
              peek_reads++;
            end else if (cur_idx == 8'hF2) begin
              for (int l = 0; l < B; l++) nic_rdata[8*l +: 8] = mem[(ptr + l) % 2048];
              ptr += B;
              f2_reads++;
            end
          end
        endcase
      end else begin
        wcnt++;
      end
    end
    prev_wait  = nic_req && !nic_ack;
    prev_kind  = nic_kind;
    prev_wdata = nic_wdata;
  end

  // ---------------- stream consumer and pulse monitor ----------------
  logic [7:0] got [0:2047];
  int         got_n, last_cnt, last_at, rreq_cnt, len_seen;
  int         cyc = 0;
  int         bp_mode = 0;
  int         hold_err = 0;
  bit         done_seen = 0;
  logic [1:0] res_seen = '0;
  logic       pv = 1'b0;
  logic       pr = 1'b0;
  logic [7:0] pd = '0;
  logic       pl = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (pv && !pr && !(out_valid && out_data == pd && out_last == pl)) hold_err++;
    out_ready = (bp_mode == 0) || (cyc % 3 != 0);
    if (out_valid && out_ready) begin
      got[got_n % 2048] = out_data;
      if (out_last) begin last_cnt++; last_at = got_n; end
      len_seen = int'(out_len);
      got_n++;
    end
    if (reset_req) rreq_cnt++;
    if (poll_done) begin done_seen = 1; res_seen = poll_result; end
    pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic plant(input logic [15:0] stat, input logic [15:0] len, input logic [7:0] seed);
    mem[0] = stat[7:0];
    mem[1] = stat[15:8];
    mem[2] = len[7:0];
    mem[3] = len[15:8];
    for (int i = 0; i < 2040; i++) mem[4 + i] = 8'(seed + 8'(i));
    marker = 8'd1;
  endtask

  task automatic run_poll();
    ptr = 0; f2_reads = 0; peek_reads = 0; isr_wb = -1; isr_wb_cnt = 0;
    imr_first = -1; imr_last = -1; imr_cnt = 0;
    got_n = 0; last_cnt = 0; last_at = -1; rreq_cnt = 0; len_seen = -1;
    done_seen = 0; hold_err = 0; bus_hold_err = 0;
    @(negedge clk); poll_start = 1'b1;
    @(negedge clk); poll_start = 1'b0;
    for (int t = 0; t < 20000 && !done_seen; t++) begin
      @(negedge clk); #1;
    end
    chk(done_seen, "R11 poll_done seen", int'(done_seen), 1);
    repeat (3) @(negedge clk);
  endtask

  function automatic int ceil_w(input int n);
    return (n + B - 1) / B;
  endfunction

  task automatic check_payload(input string tag, input int len, input logic [7:0] seed);
    int bad = 0;
    for (int i = 0; i < len; i++) if (got[i] !== 8'(seed + 8'(i))) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!out_valid, "R9 reset out_valid", int'(out_valid), 0);
    chk(!nic_req, "R12 reset nic_req", int'(nic_req), 0);
    chk(!poll_done && !reset_req, "R11 reset pulses", int'(poll_done) + int'(reset_req), 0);
  endtask

  task automatic t_empty();
    marker = 8'd0; isr_v = 8'h05; wait_n = 2;
    run_poll();
    chk(res_seen == 2'd0, "R2 empty result", int'(res_seen), 0);
    chk(peek_reads == 2, "R2 peek reads", peek_reads, 2);
    chk(f2_reads == 0, "R2 no header read", f2_reads, 0);
    chk(isr_wb == 5 && isr_wb_cnt == 1, "R1 status write-back", isr_wb, 5);
    chk(irq_status == 8'h05, "R1 irq_status", int'(irq_status), 5);
    chk(imr_first == 8'h80, "R1 quiet mask", imr_first, 128);
    chk(imr_last == 8'h83 && imr_cnt == 2, "R11 active mask", imr_last, 131);
    chk(bus_hold_err == 0, "R12 request held while waiting", bus_hold_err, 0);
  endtask

  task automatic t_deliver_odd();
    plant(16'h0000, 16'd65, 8'h10); isr_v = 8'h01; wait_n = 1; bp_mode = 1;
    run_poll();
    chk(res_seen == 2'd1, "R8 deliver result", int'(res_seen), 1);
    chk(got_n == 65, "R8 byte count", got_n, 65);
    check_payload("R8 byte order", 65, 8'h10);
    chk(last_cnt == 1 && last_at == 64, "R8 last flag", last_at, 64);
    chk(f2_reads == HW + ceil_w(65), "R4 header and payload reads", f2_reads, HW + ceil_w(65));
    chk(len_seen == 65, "R8 out_len", len_seen, 65);
    chk(hold_err == 0, "R9 stalled byte held", hold_err, 0);
    bp_mode = 0;
  endtask

  task automatic t_deliver_bounds();
    plant(16'h40FF, 16'd64, 8'h33); wait_n = 0;
    run_poll();
    chk(res_seen == 2'd1 && got_n == 64, "R7 unmasked status delivered", got_n, 64);
    check_payload("R7 payload", 64, 8'h33);
    plant(16'h0000, 16'd1536, 8'h7E);
    run_poll();
    chk(res_seen == 2'd1 && got_n == 1536, "R8 max length delivered", got_n, 1536);
    chk(f2_reads == HW + 768, "R8 max length reads", f2_reads, HW + 768);
    check_payload("R8 max payload", 1536, 8'h7E);
  endtask

  task automatic t_short();
    plant(16'h0000, 16'd63, 8'h00); wait_n = 1;
    run_poll();
    chk(res_seen == 2'd2, "R5 runt result", int'(res_seen), 2);
    chk(f2_reads == HW + 32, "R5 runt drain reads", f2_reads, HW + 32);
    chk(got_n == 0, "R5 runt no output", got_n, 0);
    plant(16'h0000, 16'd0, 8'h00);
    run_poll();
    chk(res_seen == 2'd2 && f2_reads == HW, "R5 zero length drain", f2_reads, HW);
    plant(16'h0000, 16'd1, 8'h00);
    run_poll();
    chk(f2_reads == HW + 1 && got_n == 0, "R5 one byte drain", f2_reads, HW + 1);
  endtask

  task automatic t_bad_status();
    plant(16'h0100, 16'd100, 8'h00); wait_n = 0;
    run_poll();
    chk(res_seen == 2'd2 && got_n == 0, "R7 error status drained", int'(res_seen), 2);
    chk(f2_reads == HW + 50, "R7 drain reads", f2_reads, HW + 50);
    plant(16'h8000, 16'd200, 8'h00);
    run_poll();
    chk(f2_reads == HW + 100 && got_n == 0, "R7 top status bit drained", f2_reads, HW + 100);
  endtask

  task automatic t_long();
    plant(16'h0000, 16'd1537, 8'h00); tx_busy = 1'b0;
    run_poll();
    chk(res_seen == 2'd3, "R6 long result", int'(res_seen), 3);
    chk(f2_reads == HW, "R6 no drain reads", f2_reads, HW);
    chk(rreq_cnt == 1, "R10 reset request issued", rreq_cnt, 1);
    chk(got_n == 0, "R6 no output", got_n, 0);
  endtask

  task automatic t_marker_fault();
    marker = 8'd2; tx_busy = 1'b1;
    run_poll();
    chk(res_seen == 2'd3, "R3 bad marker result", int'(res_seen), 3);
    chk(f2_reads == 0, "R3 no header read", f2_reads, 0);
    chk(rreq_cnt == 0, "R10 held while transmitting", rreq_cnt, 0);
    marker = 8'd0;
    run_poll();
    chk(rreq_cnt == 0, "R10 still held", rreq_cnt, 0);
    tx_busy = 1'b0;
    run_poll();
    chk(rreq_cnt == 1 && res_seen == 2'd0, "R10 carried reset issued", rreq_cnt, 1);
    run_poll();
    chk(rreq_cnt == 0, "R10 pending cleared", rreq_cnt, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_empty();
    t_deliver_odd();
    t_deliver_bounds();
    t_short();
    t_bad_status();
    t_long();
    t_marker_fault();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule